// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a small fully associative address translation cache. Every entry covers two adjacent virtual pages, an even page and an odd page. Both pages share one tag, one page-size mask, one address-space identifier and one global flag. Each half has its own physical frame address and its own valid, dirty, read-inhibit and execute-inhibit flags. A lookup presents a 32-bit virtual address, the current 8-bit address-space identifier and an access kind. All entries are compared in the same cycle. The result appears on registered outputs one clock later: a physical address, read and write permission flags, and a 3-bit result code.

Entries are loaded through a write port that takes an index, a write enable and every entry field. A hit can still be refused. This happens when the selected half is not valid, when a fetch targets an execute-inhibited half, when a load targets a read-inhibited half, or when a store targets a half whose dirty flag is clear. Each refusal has its own result code. The minimum page is 4 KiB, so the even/odd choice falls on address bit 12 unless the page mask widens the page.

Top module: `tlbx_lookup`

## Requirements
- R1: `rst` is synchronous and active high. While it is held, every entry is marked hidden-invalid and `rsp_valid` is low. The first lookup after reset therefore reports NOMATCH.
- R2: An entry hits only when all three of these hold:
  - its tag equals the address once the effective-mask bits are removed from both;
  - its global flag is set, or its identifier equals `lk_asid`;
  - its hidden-invalid flag is clear.
- R3: The effective mask is the page mask ORed with 0x1FFF. Setting page-mask bits therefore widens both pages of the pair and drops those bits from the tag compare.
- R4: The odd half is selected when the address bit at the top of the effective mask is 1. With a zero page mask this is bit 12.
- R5: On a hit, the checks below run in this order, and the first one that applies sets the code. If none applies, the code is MATCH.
  - The selected half is not valid: INVALID.
  - Fetch (`lk_acc`=00) with execute-inhibit set: XI.
  - Load (01) with read-inhibit set: RI.
  - Store (10) with dirty clear: DIRTY.
  - Code 11 is subject to the valid check only.
- R6: On MATCH, `rsp_paddr` is the selected frame address ORed with the virtual address bits under the effective mask shifted right by one. On any other code, `rsp_paddr` is 0.
- R7: `rsp_rd_ok` is 1 exactly on MATCH. `rsp_wr_ok` is 1 only on MATCH with the selected half's dirty flag set.
- R8: A lookup that no entry hits reports NOMATCH.
- R9: The codes are MATCH=000, BADADDR=111, NOMATCH=110, INVALID=101, DIRTY=100, RI=011 and XI=010. BADADDR is never produced by this block.
- R10: When several entries hit, the lowest-indexed entry decides the outcome.
- R11: A lookup with `lk_valid` high is answered with `rsp_valid` high one clock later. Without a request, `rsp_valid` is low one clock later. An entry written on one clock edge is used by a lookup sampled on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_acc | input | 2 | Access kind: 00 fetch, 01 load, 10 store |
| wr_en | input | 1 | Entry write enable |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 32 | Virtual tag of the page pair |
| wr_pmask | input | 32 | Page-size mask |
| wr_asid | input | 8 | Entry address-space identifier |
| wr_glob | input | 1 | Entry matches any identifier |
| wr_hinv | input | 1 | Hidden-invalid: entry never hits |
| wr_pfn0 | input | 32 | Even-half physical frame address |
| wr_v0 | input | 1 | Even-half valid |
| wr_d0 | input | 1 | Even-half dirty (writable) |
| wr_ri0 | input | 1 | Even-half read-inhibit |
| wr_xi0 | input | 1 | Even-half execute-inhibit |
| wr_pfn1 | input | 32 | Odd-half physical frame address |
| wr_v1 | input | 1 | Odd-half valid |
| wr_d1 | input | 1 | Odd-half dirty (writable) |
| wr_ri1 | input | 1 | Odd-half read-inhibit |
| wr_xi1 | input | 1 | Odd-half execute-inhibit |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_code | output | 3 | Result code |

## Verification
The bench looks up both halves of a 4 KiB pair and of a 64 KiB pair. This separates a wrong select bit from a wrong offset mask, and an address just past the wide pair must miss. It uses entries that differ only in identifier, global flag or hidden-invalid flag, which isolates each term of the hit condition. A single half that has every inhibit flag set and dirty clear is visited by fetch, load and store, and then again with valid cleared. This exposes any reordering of the refusal checks. Two entries that overlap on the same tag, with the lower one later rewritten as hidden-invalid, show lowest-index priority and next-cycle write visibility.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  parameter int VA_W     = 32;
  parameter int PA_W     = 32;
  parameter int ASID_W   = 8;
  parameter int PG_SHIFT = 12;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    RC_MATCH   = 3'b000,
    RC_XI      = 3'b010,
    RC_RI      = 3'b011,
    RC_DIRTY   = 3'b100,
    RC_INVALID = 3'b101,
    RC_NOMATCH = 3'b110,
    RC_BADADDR = 3'b111
  } rcode_e;

  typedef struct packed {
    logic [PA_W-1:0] pfn;
    logic            v;
    logic            d;
    logic            ri;
    logic            xi;
  } half_t;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   pmask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              hinv;
    half_t [1:0]       half;
  } entry_t;
endpackage

// File: rtl/tlbx_entry_store.sv
module tlbx_entry_store
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_data,
  output entry_t           ent_q [ENTRIES]
);
  // Flop array: every row must be visible at once for the parallel compare.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[g]      <= '0;
        ent_q[g].hinv <= 1'b1;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ent_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tlbx_match_row.sv
module tlbx_match_row
  import tlbx_pkg::*;
(
  input  entry_t            ent,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              hit,
  output logic              odd,
  output logic [VA_W-1:0]   offmask
);
  localparam logic [VA_W-1:0] PAIR_MASK = VA_W'((64'd1 << (PG_SHIFT + 1)) - 64'd1);

  logic [VA_W-1:0] emask;
  logic            tag_eq;
  logic            id_ok;

  always_comb begin
    emask   = ent.pmask | PAIR_MASK;
    offmask = emask >> 1;
    tag_eq  = (ent.vpn & ~emask) == (va & ~emask);
    id_ok   = ent.glob || (ent.asid == cur_asid);
    hit     = tag_eq && id_ok && !ent.hinv;
    // top bit inside the effective mask picks the half
    odd     = |(va & emask & ~offmask);
  end
endmodule

// File: rtl/tlbx_prio_sel.sv
module tlbx_prio_sel #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   sel_idx
);
  always_comb begin
    any_hit = 1'b0;
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic              wr_hinv,
  input  logic [PA_W-1:0]   wr_pfn0,
  input  logic              wr_v0,
  input  logic              wr_d0,
  input  logic              wr_ri0,
  input  logic              wr_xi0,
  input  logic [PA_W-1:0]   wr_pfn1,
  input  logic              wr_v1,
  input  logic              wr_d1,
  input  logic              wr_ri1,
  input  logic              wr_xi1,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_rd_ok,
  output logic              rsp_wr_ok,
  output logic [2:0]        rsp_code
);
  entry_t            wr_data;
  entry_t            ent_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] odd_vec;
  logic [VA_W-1:0]   off_arr [ENTRIES];
  logic              any_hit;
  logic [IDX_W-1:0]  sel_idx;

  half_t             sel_half;
  logic [VA_W-1:0]   sel_off;
  rcode_e            nxt_code;
  logic [PA_W-1:0]   nxt_pa;
  logic              nxt_wr;

  always_comb begin
    wr_data.vpn          = wr_vpn;
    wr_data.pmask        = wr_pmask;
    wr_data.asid         = wr_asid;
    wr_data.glob         = wr_glob;
    wr_data.hinv         = wr_hinv;
    wr_data.half[0].pfn  = wr_pfn0;
    wr_data.half[0].v    = wr_v0;
    wr_data.half[0].d    = wr_d0;
    wr_data.half[0].ri   = wr_ri0;
    wr_data.half[0].xi   = wr_xi0;
    wr_data.half[1].pfn  = wr_pfn1;
    wr_data.half[1].v    = wr_v1;
    wr_data.half[1].d    = wr_d1;
    wr_data.half[1].ri   = wr_ri1;
    wr_data.half[1].xi   = wr_xi1;
  end

  tlbx_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .ent_q  (ent_q)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlbx_match_row u_row (
      .ent     (ent_q[g]),
      .va      (lk_vaddr),
      .cur_asid(lk_asid),
      .hit     (hit_vec[g]),
      .odd     (odd_vec[g]),
      .offmask (off_arr[g])
    );
  end

  tlbx_prio_sel #(.ENTRIES(ENTRIES)) u_sel (
    .hit_vec(hit_vec),
    .any_hit(any_hit),
    .sel_idx(sel_idx)
  );

  always_comb begin
    sel_half = ent_q[sel_idx].half[odd_vec[sel_idx]];
    sel_off  = off_arr[sel_idx];
    nxt_pa   = '0;
    nxt_wr   = 1'b0;
    if (!any_hit)                                   nxt_code = RC_NOMATCH;
    else if (!sel_half.v)                           nxt_code = RC_INVALID;
    else if (lk_acc == ACC_FETCH && sel_half.xi)    nxt_code = RC_XI;
    else if (lk_acc == ACC_LOAD && sel_half.ri)     nxt_code = RC_RI;
    else if (lk_acc == ACC_STORE && !sel_half.d)    nxt_code = RC_DIRTY;
    else begin
      nxt_code = RC_MATCH;
      nxt_pa   = sel_half.pfn | PA_W'(lk_vaddr & sel_off);
      nxt_wr   = sel_half.d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_rd_ok <= 1'b0;
      rsp_wr_ok <= 1'b0;
      rsp_code  <= RC_NOMATCH;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_paddr <= nxt_pa;
        rsp_rd_ok <= (nxt_code == RC_MATCH);
        rsp_wr_ok <= nxt_wr;
        rsp_code  <= nxt_code;
      end
    end
  end
endmodule

// File: rtl/tlbx_lookup_chk.sv
module tlbx_lookup_chk
  import tlbx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic [1:0]        lk_acc,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              rsp_rd_ok,
  input logic              rsp_wr_ok,
  input logic [2:0]        rsp_code
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !rsp_valid); // R1
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid); // R11
  AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid); // R11
  AST_WR_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wr_ok) |-> (rsp_code == RC_MATCH && rsp_rd_ok)); // R7
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code != RC_BADADDR && rsp_code != 3'b001)); // R9
  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != RC_MATCH) |-> (rsp_paddr == '0 && !rsp_rd_ok)); // R6
  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RC_MATCH) |->
      ((rsp_paddr[PG_SHIFT-1:0] & $past(lk_vaddr[PG_SHIFT-1:0])) == $past(lk_vaddr[PG_SHIFT-1:0]))); // R6
  AST_STORE_MATCH_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RC_MATCH && $past(lk_acc) == ACC_STORE) |-> rsp_wr_ok); // R5
endmodule

bind tlbx_lookup tlbx_lookup_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .lk_vaddr (lk_vaddr),
  .lk_acc   (lk_acc),
  .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr),
  .rsp_rd_ok(rsp_rd_ok),
  .rsp_wr_ok(rsp_wr_ok),
  .rsp_code (rsp_code)
);

// File: tb/tlbx_lookup_tb.sv
module tlbx_lookup_tb;
  import tlbx_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_acc = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  entry_t      we = '0;
  logic        rsp_valid, rsp_rd_ok, rsp_wr_ok;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_code;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tlbx_lookup u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_acc(lk_acc), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(we.vpn), .wr_pmask(we.pmask), .wr_asid(we.asid),
    .wr_glob(we.glob), .wr_hinv(we.hinv),
    .wr_pfn0(we.half[0].pfn), .wr_v0(we.half[0].v), .wr_d0(we.half[0].d),
    .wr_ri0(we.half[0].ri), .wr_xi0(we.half[0].xi),
    .wr_pfn1(we.half[1].pfn), .wr_v1(we.half[1].v), .wr_d1(we.half[1].d),
    .wr_ri1(we.half[1].ri), .wr_xi1(we.half[1].xi),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_rd_ok(rsp_rd_ok),
    .rsp_wr_ok(rsp_wr_ok), .rsp_code(rsp_code)
  );

  localparam logic [2:0] C_MATCH = 3'b000, C_NOMATCH = 3'b110, C_INVALID = 3'b101,
                         C_DIRTY = 3'b100, C_RI = 3'b011, C_XI = 3'b010;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic half_t mk_half(input logic [31:0] pfn, input logic v, input logic d,
                                    input logic ri, input logic xi);
    half_t h;
    h.pfn = pfn; h.v = v; h.d = d; h.ri = ri; h.xi = xi;
    return h;
  endfunction

  task automatic put(input logic [3:0] idx, input logic [31:0] vpn, input logic [31:0] pm,
                     input logic [7:0] asid, input logic glob, input logic hinv,
                     input half_t h0, input half_t h1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx;
    we.vpn = vpn; we.pmask = pm; we.asid = asid; we.glob = glob; we.hinv = hinv;
    we.half[0] = h0; we.half[1] = h1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive at a falling edge, result registered at the rising edge, sample at the next falling edge
  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_acc = acc;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] pa, input logic wr);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " code"}, 32'(rsp_code), 32'(C_MATCH));
    chk({tag, " paddr"}, rsp_paddr, pa);
    chk({tag, " rd_ok"}, 32'(rsp_rd_ok), 32'd1);
    chk({tag, " wr_ok"}, 32'(rsp_wr_ok), 32'(wr));
  endtask

  task automatic expect_code(input string tag, input logic [2:0] c);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " code"}, 32'(rsp_code), 32'(c));
    chk({tag, " paddr"}, rsp_paddr, 32'd0);
    chk({tag, " wr_ok"}, 32'(rsp_wr_ok), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    look(32'h0000_0000, 8'd0, 2'b01);
    expect_code("R1 R8 empty after reset", C_NOMATCH);
    @(negedge clk);
    chk("R11 idle gives no response", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_pair_small();
    put(4'd0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0,
        mk_half(32'h1000_0000, 1, 1, 0, 0), mk_half(32'h2000_0000, 1, 0, 0, 0));
    look(32'h0040_0123, 8'd5, 2'b01);
    expect_hit("R4 R6 R7 even half load", 32'h1000_0123, 1'b1);
    look(32'h0040_1ABC, 8'd5, 2'b01);
    expect_hit("R4 R6 R7 odd half load", 32'h2000_0ABC, 1'b0);
    look(32'h0040_1ABC, 8'd5, 2'b10);
    expect_code("R5 odd store not dirty", C_DIRTY);
    look(32'h0040_0FFF, 8'd5, 2'b10);
    expect_hit("R7 even store dirty", 32'h1000_0FFF, 1'b1);
    look(32'h0040_2000, 8'd5, 2'b01);
    expect_code("R8 next pair misses", C_NOMATCH);
  endtask

  task automatic t_ident();
    look(32'h0040_0010, 8'd6, 2'b01);
    expect_code("R2 wrong identifier", C_NOMATCH);
    put(4'd5, 32'h0700_0000, 32'h0, 8'd9, 1'b1, 1'b0,
        mk_half(32'h0A00_0000, 1, 1, 0, 0), mk_half(32'h0B00_0000, 1, 1, 0, 0));
    look(32'h0700_0044, 8'd77, 2'b00);
    expect_hit("R2 global ignores identifier", 32'h0A00_0044, 1'b1);
    put(4'd5, 32'h0700_0000, 32'h0, 8'd9, 1'b1, 1'b1,
        mk_half(32'h0A00_0000, 1, 1, 0, 0), mk_half(32'h0B00_0000, 1, 1, 0, 0));
    look(32'h0700_0044, 8'd9, 2'b00);
    expect_code("R2 hidden-invalid never hits", C_NOMATCH);
  endtask

  task automatic t_mask();
    put(4'd1, 32'h0100_0000, 32'h0001_E000, 8'd5, 1'b0, 1'b0,
        mk_half(32'h4000_0000, 1, 1, 0, 0), mk_half(32'h3000_0000, 1, 1, 0, 0));
    look(32'h0101_2345, 8'd5, 2'b01);
    expect_hit("R3 R4 wide pair odd (bit 16)", 32'h3000_2345, 1'b1);
    look(32'h0100_F000, 8'd5, 2'b01);
    expect_hit("R3 R6 wide pair even", 32'h4000_F000, 1'b1);
    look(32'h0102_0000, 8'd5, 2'b01);
    expect_code("R3 past wide pair", C_NOMATCH);
  endtask

  task automatic t_order();
    put(4'd6, 32'h0900_0000, 32'h0, 8'd0, 1'b1, 1'b0,
        mk_half(32'h5000_0000, 1, 0, 1, 1), mk_half(32'h6000_0000, 0, 0, 1, 1));
    look(32'h0900_0008, 8'd0, 2'b00);
    expect_code("R5 fetch with XI", C_XI);
    look(32'h0900_0008, 8'd0, 2'b01);
    expect_code("R5 load with RI", C_RI);
    look(32'h0900_0008, 8'd0, 2'b10);
    expect_code("R5 store with dirty clear", C_DIRTY);
    look(32'h0900_0008, 8'd0, 2'b11);
    expect_hit("R5 reserved access valid only", 32'h5000_0008, 1'b0);
    look(32'h0900_1008, 8'd0, 2'b00);
    expect_code("R5 invalid before XI", C_INVALID);
    look(32'h0900_1008, 8'd0, 2'b10);
    expect_code("R5 invalid before DIRTY", C_INVALID);
  endtask

  task automatic t_prio();
    put(4'd3, 32'h0080_0000, 32'h0, 8'd0, 1'b1, 1'b0,
        mk_half(32'h7700_0000, 1, 1, 0, 0), mk_half(32'h7800_0000, 1, 1, 0, 0));
    put(4'd2, 32'h0080_0000, 32'h0, 8'd0, 1'b1, 1'b0,
        mk_half(32'h6600_0000, 1, 0, 0, 0), mk_half(32'h6800_0000, 1, 0, 0, 0));
    look(32'h0080_0100, 8'd3, 2'b01);
    expect_hit("R10 lower index wins", 32'h6600_0100, 1'b0);
    put(4'd2, 32'h0080_0000, 32'h0, 8'd0, 1'b1, 1'b1,
        mk_half(32'h6600_0000, 1, 0, 0, 0), mk_half(32'h6800_0000, 1, 0, 0, 0));
    look(32'h0080_1100, 8'd3, 2'b10);
    expect_hit("R11 rewrite seen next cycle", 32'h7800_0100, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pair_small();
        t_ident();
        t_mask();
        t_order();
        t_prio();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule